// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the byte stream that a MAC hands up from the receive path and decides whether a frame carries a wake-on-LAN magic pattern for this station. The pattern consists of six 0xFF synchronisation bytes followed by sixteen back-to-back copies of the 48-bit station address. The block skips the destination and source address fields of each frame and then searches every later byte for the pattern, whatever its offset. A hit only counts if the frame then closes with a good CRC.

Detection depends on the power state. In the fully powered state a software enable bit must be set. In the doze state the search runs on its own, and the block also raises an arm signal for a companion wake-frame filter. In the two deeper states the search logic is held cleared. A wake produces a one-cycle pulse and sets a status flag that stays set until software clears it.

Top module: `mp_wake_detect`

## Requirements
- R1: After reset, `wake_pulse` and `wake_status` are 0.
- R2: In state ON (`pwr_state`=0) with `sw_enable`=1, a frame holding 12 header bytes, then six 0xFF bytes, then sixteen address copies, and ending with `rx_crc_ok`=1 on its `rx_eof` byte, gives `wake_pulse`=1 in the cycle after that end byte is taken.
- R3: The first 12 bytes of a frame (the two address fields) are never searched. The sync run may begin at any later byte.
- R4: Each address copy is compared in wire order: the first byte against `station_addr[47:40]`, the last against `station_addr[7:0]`. All sixteen copies must match.
- R5: A byte that breaks the sync run or an address copy restarts the search. If that byte is 0xFF, it counts as the first sync byte of a new run.
- R6: A sync run longer than six 0xFF bytes is accepted, provided `station_addr[47:40]` is not 0xFF.
- R7: A frame whose end byte carries `rx_crc_ok`=0 gives no wake. So does a frame that a new `rx_sof` cuts off before its end.
- R8: In state ON with `sw_enable`=0, no wake is produced.
- R9: In state DOZE (`pwr_state`=1), detection runs whatever the value of `sw_enable`, and `wf_arm` is 1. In all other states `wf_arm` is 0.
- R10: In states SLEEP (2) and OFF (3), the search is held cleared and no wake is produced. A visit to either state in the middle of a frame discards the progress made so far in that frame.
- R11: `wake_status` is set with each wake and stays set until `status_clr` is sampled high. A wake in the same cycle as a clear leaves it set.
- R12: `wake_pulse` is high for exactly one cycle per wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_crc_ok | input | 1 | Frame CRC good, read together with `rx_eof` |
| rx_data | input | 8 | Receive byte |
| station_addr | input | 48 | Station address, first wire byte in bits 47:40 |
| pwr_state | input | 2 | 0 ON, 1 DOZE, 2 SLEEP, 3 OFF |
| sw_enable | input | 1 | Software enable, used in state ON |
| status_clr | input | 1 | Clears `wake_status` |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_status | output | 1 | Sticky wake flag |
| wf_arm | output | 1 | Arms the wake-frame filter (DOZE only) |

## Verification
The bench builds the block with its default parameters: 12 header bytes, a 6-byte sync run, a 6-byte address and 16 copies. This is the full pattern length, so the counter terminal values and the completion of the last copy are exercised exactly as in service. The station address starts with 0x02. This brings two cases within reach. First, a broadcast destination field of 0xFF bytes in the header must stay invisible to the search. Second, extra sync bytes and a 0xFF that breaks an address copy each take their own path through the restart logic.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
    typedef enum logic [1:0] {
        PWR_ON    = 2'd0,
        PWR_DOZE  = 2'd1,
        PWR_SLEEP = 2'd2,
        PWR_OFF   = 2'd3
    } pwr_e;

    typedef enum logic {
        PH_SYNC = 1'b0,
        PH_ADDR = 1'b1
    } phase_e;
endpackage

// File: rtl/mpw_power_gate.sv
module mpw_power_gate
    import mpw_pkg::*;
(
    input  logic [1:0] pwr_state,
    input  logic       sw_enable,
    output logic       search_en,
    output logic       wf_arm
);
    always_comb begin
        search_en = 1'b0;
        wf_arm    = 1'b0;
        unique case (pwr_e'(pwr_state))
            PWR_ON:   search_en = sw_enable;
            PWR_DOZE: begin
                search_en = 1'b1;
                wf_arm    = 1'b1;
            end
            default:  search_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/mpw_pattern_match.sv
module mpw_pattern_match
    import mpw_pkg::*;
#(
    parameter int HDR_BYTES  = 12,
    parameter int SYNC_LEN   = 6,
    parameter int ADDR_BYTES = 6,
    parameter int ADDR_REPS  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    search_en,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_crc_ok,
    input  logic [7:0]              rx_data,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    output logic                    match_evt
);
    localparam int HW = $clog2(HDR_BYTES + 1);
    localparam int SW = $clog2(SYNC_LEN + 1);
    localparam int IW = $clog2(ADDR_BYTES);
    localparam int RW = $clog2(ADDR_REPS + 1);

    typedef struct packed {
        logic          in_frame;
        logic          found;
        phase_e        phase;
        logic [HW-1:0] hdr_cnt;
        logic [SW-1:0] sync_cnt;
        logic [IW-1:0] idx;
        logic [RW-1:0] rep;
    } st_t;

    st_t        s_q, s_d;
    logic [7:0] exp_byte;
    logic       is_ff;
    logic       prior_found;

    always_comb begin
        exp_byte    = station_addr[8*(ADDR_BYTES-1-int'(s_q.idx)) +: 8];
        is_ff       = (rx_data == 8'hFF);
        s_d         = s_q;
        match_evt   = 1'b0;
        prior_found = s_q.found && !rx_sof;
        if (rx_valid) begin
            if (rx_sof) begin
                s_d          = '0;
                s_d.in_frame = 1'b1;
            end
            if (s_d.in_frame) begin
                if (s_d.hdr_cnt != HW'(HDR_BYTES)) begin
                    s_d.hdr_cnt = s_d.hdr_cnt + 1'b1;
                end else if (!s_d.found) begin
                    if (s_d.phase == PH_SYNC) begin
                        if (!is_ff) begin
                            s_d.sync_cnt = '0;
                        end else if (s_d.sync_cnt == SW'(SYNC_LEN - 1)) begin
                            s_d.phase    = PH_ADDR;
                            s_d.sync_cnt = '0;
                            s_d.idx      = '0;
                            s_d.rep      = '0;
                        end else begin
                            s_d.sync_cnt = s_d.sync_cnt + 1'b1;
                        end
                    end else if (rx_data == exp_byte) begin
                        if (s_d.idx == IW'(ADDR_BYTES - 1)) begin
                            s_d.idx = '0;
                            if (s_d.rep == RW'(ADDR_REPS - 1)) begin
                                s_d.found = 1'b1;
                                s_d.phase = PH_SYNC;
                                s_d.rep   = '0;
                            end else begin
                                s_d.rep = s_d.rep + 1'b1;
                            end
                        end else begin
                            s_d.idx = s_d.idx + 1'b1;
                        end
                    end else if (is_ff && s_d.idx == '0 && s_d.rep == '0) begin
                        // extra sync byte before the first copy: keep waiting
                        s_d.phase = PH_ADDR;
                    end else begin
                        s_d.phase    = PH_SYNC;
                        s_d.idx      = '0;
                        s_d.rep      = '0;
                        s_d.sync_cnt = is_ff ? SW'(1) : '0;
                    end
                end
                if (rx_eof) begin
                    match_evt = prior_found && rx_crc_ok;
                    s_d       = '0;
                end
            end
        end
        if (!search_en) begin
            s_d       = '0;
            match_evt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/mpw_wake_status.sv
module mpw_wake_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_evt,
    input  logic status_clr,
    output logic wake_pulse,
    output logic wake_status
);
    typedef struct packed {
        logic pulse;
        logic status;
    } ws_t;

    ws_t w_q, w_d;

    always_comb begin
        w_d.pulse  = wake_evt;
        w_d.status = wake_evt | (w_q.status & ~status_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wake_pulse  = w_q.pulse;
    assign wake_status = w_q.status;
endmodule

// File: rtl/mp_wake_detect.sv
module mp_wake_detect
    import mpw_pkg::*;
#(
    parameter int HDR_BYTES  = 12,
    parameter int SYNC_LEN   = 6,
    parameter int ADDR_BYTES = 6,
    parameter int ADDR_REPS  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_crc_ok,
    input  logic [7:0]              rx_data,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic [1:0]              pwr_state,
    input  logic                    sw_enable,
    input  logic                    status_clr,
    output logic                    wake_pulse,
    output logic                    wake_status,
    output logic                    wf_arm
);
    logic search_en;
    logic match_evt;

    mpw_power_gate u_gate (
        .pwr_state (pwr_state),
        .sw_enable (sw_enable),
        .search_en (search_en),
        .wf_arm    (wf_arm)
    );

    mpw_pattern_match #(
        .HDR_BYTES  (HDR_BYTES),
        .SYNC_LEN   (SYNC_LEN),
        .ADDR_BYTES (ADDR_BYTES),
        .ADDR_REPS  (ADDR_REPS)
    ) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .search_en    (search_en),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_crc_ok    (rx_crc_ok),
        .rx_data      (rx_data),
        .station_addr (station_addr),
        .match_evt    (match_evt)
    );

    mpw_wake_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_evt    (match_evt),
        .status_clr  (status_clr),
        .wake_pulse  (wake_pulse),
        .wake_status (wake_status)
    );
endmodule

// File: rtl/mpw_checker.sv
module mpw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_eof,
    input logic       rx_crc_ok,
    input logic [1:0] pwr_state,
    input logic       sw_enable,
    input logic       status_clr,
    input logic       wake_pulse,
    input logic       wake_status
);
    // R2 and R7: a wake follows only a good-CRC end byte
    p_wake_after_good_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(rx_valid && rx_eof && rx_crc_ok));

    // R8: ON state without the enable never wakes
    p_no_wake_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && !sw_enable) |=> !wake_pulse);

    // R10: deep states never wake
    p_no_wake_deep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state[1] |=> !wake_pulse);

    // R11: the pulse is always reflected in status
    p_status_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> wake_status);

    // R11: status drops only after a clear
    p_status_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_status) |-> $past(status_clr));

    // R12: single-cycle pulse
    p_pulse_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
endmodule

bind mp_wake_detect mpw_checker u_chk (.*);

// File: tb/sim_mp_wake_detect.sv
module sim_mp_wake_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic [1:0]  pwr_state = 2'd0;
    logic        sw_enable = 1'b0, status_clr = 1'b0;
    logic        wake_pulse, wake_status, wf_arm;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit st_model = 0;
    logic [7:0] fq[$];
    bit    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    mp_wake_detect u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input bit sof, input bit eof,
                             input bit crc, input bit expw, input string tag, input bit clr);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_sof = sof; rx_eof = eof; rx_crc_ok = crc;
        status_clr = clr;
        if (eof) begin
            exp_q.push_back(expw);
            tag_q.push_back(tag);
            if (expw) st_model = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; status_clr = 1'b0;
        end
    endtask

    task automatic add_hdr();
        for (int i = 0; i < 6; i++) fq.push_back(8'hA0 + 8'(i));
        for (int i = 0; i < 6; i++) fq.push_back(8'hB0 + 8'(i));
    endtask
    task automatic add_ff(input int n);
        for (int i = 0; i < n; i++) fq.push_back(8'hFF);
    endtask
    task automatic add_addr(input int reps, input logic [47:0] a);
        for (int r = 0; r < reps; r++)
            for (int b = 5; b >= 0; b--) fq.push_back(a[8*b +: 8]);
    endtask
    task automatic add_junk(input int n);
        for (int i = 0; i < n; i++) fq.push_back(8'h30 + 8'(i));
    endtask

    // send fq as one frame plus 4 CRC bytes; clears fq
    task automatic send_frame(input bit crc, input bit expw, input string tag);
        add_junk(4);
        for (int i = 0; i < fq.size(); i++)
            send_byte(fq[i], i == 0, i == fq.size() - 1, crc, expw, tag, 1'b0);
        fq.delete();
        idle(3);
    endtask

    task automatic clear_status();
        @(negedge clk);
        status_clr = 1'b1;
        st_model = 1'b0;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    task automatic check_status(input string tag);
        chk(wake_status == st_model, tag, wake_status, st_model);
    endtask

    // monitor: pops one expected wake per end byte taken
    initial begin
        forever begin
            bit took_end;
            @(posedge clk);
            took_end = rx_valid && rx_eof && rst_n;
            #1;
            if (took_end && exp_q.size() > 0) begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(wake_pulse == e, t, wake_pulse, e);
            end else if (wake_pulse && rst_n && !took_end) begin
                total++;
                bad++;
                $display("FAIL R12 stray wake_pulse actual=1 expected=0");
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        chk(wake_pulse == 0, "R1 pulse", wake_pulse, 0);
        chk(wake_status == 0, "R1 status", wake_status, 0);
        @(negedge clk); rst_n = 1'b1;
        pwr_state = 2'd0; sw_enable = 1'b1;
        idle(2);
        chk(wf_arm == 0, "R9 wf_arm in ON", wf_arm, 0);

        // R2 basic match, R12 pulse width
        add_hdr(); add_ff(6); add_addr(16, station_addr);
        add_junk(4);
        for (int i = 0; i < fq.size(); i++)
            send_byte(fq[i], i == 0, i == fq.size() - 1, 1'b1, 1'b1, "R2 basic match", 1'b0);
        fq.delete();
        @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0; rx_sof = 1'b0;
        chk(wake_pulse == 1, "R12 pulse high", wake_pulse, 1);
        @(negedge clk);
        chk(wake_pulse == 0, "R12 pulse one cycle", wake_pulse, 0);
        check_status("R11 status set");

        // R7 bad CRC, status sticky
        add_hdr(); add_ff(6); add_addr(16, station_addr);
        send_frame(1'b0, 1'b0, "R7 bad crc");
        check_status("R11 status sticky");
        clear_status();
        check_status("R11 status cleared");

        // R3 offset inside payload
        add_hdr(); add_junk(7); add_ff(6); add_addr(16, station_addr);
        send_frame(1'b1, 1'b1, "R3 payload offset");
        clear_status();

        // R3 header with broadcast destination is not searched
        add_ff(6); add_addr(1, station_addr); add_addr(16, station_addr);
        send_frame(1'b1, 1'b0, "R3 header skipped");

        // R4 byte-reversed address
        add_hdr(); add_ff(6); add_addr(16, 48'h55_44_33_22_11_02);
        send_frame(1'b1, 1'b0, "R4 reversed order");

        // R4 last copy wrong
        add_hdr(); add_ff(6); add_addr(15, station_addr); add_addr(1, 48'h02_11_22_33_44_56);
        send_frame(1'b1, 1'b0, "R4 last copy mismatch");

        // R5 break by 0xFF counts as first sync byte
        add_hdr(); add_ff(6); add_addr(3, station_addr); add_ff(6);
        add_addr(16, station_addr);
        send_frame(1'b1, 1'b1, "R5 restart on ff");
        clear_status();

        // R5 broken sync run
        add_hdr(); add_ff(4); add_junk(1); add_ff(1); add_addr(16, station_addr);
        send_frame(1'b1, 1'b0, "R5 broken sync");

        // R6 long sync run
        add_hdr(); add_ff(9); add_addr(16, station_addr);
        send_frame(1'b1, 1'b1, "R6 long sync");
        clear_status();

        // R7 truncated frame then header-only good frame
        add_hdr(); add_ff(6); add_addr(16, station_addr);
        for (int i = 0; i < fq.size(); i++)
            send_byte(fq[i], i == 0, 1'b0, 1'b1, 1'b0, "", 1'b0);
        fq.delete();
        add_hdr();
        send_frame(1'b1, 1'b0, "R7 truncated");

        // R8 ON without enable
        sw_enable = 1'b0;
        add_hdr(); add_ff(6); add_addr(16, station_addr);
        send_frame(1'b1, 1'b0, "R8 enable off");
        check_status("R8 status untouched");

        // R9 DOZE ignores enable
        pwr_state = 2'd1;
        idle(1);
        chk(wf_arm == 1, "R9 wf_arm in DOZE", wf_arm, 1);
        add_hdr(); add_ff(6); add_addr(16, station_addr);
        send_frame(1'b1, 1'b1, "R9 doze auto enable");
        clear_status();

        // R10 SLEEP and OFF
        for (int s = 2; s < 4; s++) begin
            pwr_state = 2'(s);
            idle(1);
            chk(wf_arm == 0, "R9 wf_arm deep", wf_arm, 0);
            add_hdr(); add_ff(6); add_addr(16, station_addr);
            send_frame(1'b1, 1'b0, "R10 deep state");
        end

        // R10 mid-frame visit to SLEEP discards progress
        pwr_state = 2'd1;
        add_hdr(); add_ff(6); add_addr(16, station_addr);
        for (int i = 0; i < fq.size(); i++)
            send_byte(fq[i], i == 0, 1'b0, 1'b1, 1'b0, "", 1'b0);
        fq.delete();
        idle(1);
        pwr_state = 2'd2;
        idle(2);
        pwr_state = 2'd1;
        for (int i = 0; i < 4; i++)
            send_byte(8'h30, 1'b0, i == 3, 1'b1, 1'b0, "R10 mid-frame sleep", 1'b0);
        idle(3);
        check_status("R10 status untouched");

        // R11 wake and clear in the same cycle: status stays set
        add_hdr(); add_ff(6); add_addr(16, station_addr); add_junk(4);
        for (int i = 0; i < fq.size(); i++)
            send_byte(fq[i], i == 0, i == fq.size() - 1, 1'b1, 1'b1,
                      "R11 wake with clear", i == fq.size() - 1);
        fq.delete();
        idle(3);
        check_status("R11 set wins over clear");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule